// File: doc/BRIEF.md
# Closed-Loop Frequency Tracking Oscillator

This block steers a numerically controlled oscillator (a phase accumulator) until its output frequency matches an unknown input frequency. An external frequency comparator reports one bit per clock. A 1 means the synthesized frequency is below the unknown frequency, and a 0 means it is above. The block keeps a tuning word that is the accumulator increment. The synthesized frequency is therefore tuning word × fclk / 2^ACC_W, and the resolution is fclk / 2^ACC_W.

The tuning word is found by a search in the style of successive approximation. An adjustment step is added to the tuning word when the comparator asks for a higher frequency and subtracted when it asks for a lower one. Each time the comparator bit reverses, the step is halved, down to a minimum of 1. Near the target the comparator keeps alternating. This is expected, and the loop keeps tracking with the unit step. A lock flag reports when the unit step has been reached and the comparator has reversed twice at that step. The accumulator MSB is the square-wave output.

Top module: `dds_freq_tracker`

## Requirements
- R1: During and directly after a synchronous active-high reset, the tuning word is 0, the lock flag is 0 and the square-wave output is 0. The adjustment step restarts at 2^(ACC_W-3).
- R2: On the first enabled clock after reset, the comparator bit cannot count as a reversal. With a bit of 1 the tuning word becomes 2^(ACC_W-3).
- R3: On each enabled clock the tuning word changes by the current step. The direction bit 1 (frequency too low) adds the step, and 0 (too high) subtracts it. The result appears on the tuning-word output after that same clock edge.
- R4: The step is halved, with a floor of 1, on an enabled clock whose comparator bit differs from the bit of the previous enabled clock. The halved step is the one applied in that clock. Without a reversal the step is unchanged, and the step never grows except through reset.
- R5: The tuning word saturates at 2^(ACC_W-2), a quarter of the clock frequency. An upward move that would pass that value gives exactly 2^(ACC_W-2).
- R6: A downward move that would reach 0 or less gives 1. Once the tuning word is nonzero it never returns to 0.
- R7: With the enable low, the tuning word, the step, the lock flag and the remembered comparator bit all hold. The reversal test on the next enabled clock compares against the last enabled sample.
- R8: The lock flag goes to 1 on the enabled clock that completes the second reversal seen while the step was already 1. It stays 1 until reset.
- R9: The phase accumulator adds the tuning word on every clock. The square-wave output is its MSB, with a period of 2^ACC_W / tuning word clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables one search update per clock |
| dir_i | input | 1 | Comparator bit: 1 means synthesized frequency too low |
| tw_o | output | ACC_W | Current tuning word |
| sq_o | output | 1 | Accumulator MSB, square-wave output |
| lock_o | output | 1 | Search has settled at the unit step |

## Verification
The assertions take the comparator bit and the enable to be clean synchronous levels that are stable at the sampling edge. They also take reset to be asserted at time zero, so every register starts from its defined state. The bench changes inputs only on the falling clock edge and holds reset from the start. The reversal sequences in the bench take the step from its start value down to 1 through every halving. They also drive the tuning word into both the ceiling and the floor, so that the saturation assertions are exercised by stimulus the requirements permit.

// File: rtl/dds_trk_pkg.sv
package dds_trk_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

endpackage

// File: rtl/dds_step_ctrl.sv
module dds_step_ctrl #(
  parameter int ACC_W     = 32,
  parameter int LOCK_REVS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             dir_i,
  output logic [ACC_W-1:0] step_nxt_o,
  output logic             lock_o
);

  localparam logic [ACC_W-1:0] STEP_INIT = ACC_W'(1) << (ACC_W - 3);
  localparam logic [ACC_W-1:0] STEP_MIN  = ACC_W'(1);
  localparam int               CNT_W     = $clog2(LOCK_REVS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(LOCK_REVS);

  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] step_half;
  logic             prev_dir_q;
  logic             primed_q;
  logic             reversal;
  logic [CNT_W-1:0] rev_cnt_q;
  logic [CNT_W-1:0] rev_cnt_nxt;
  logic             lock_q;

  assign reversal  = primed_q && (dir_i != prev_dir_q);
  assign step_half = step_q >> 1;

  always_comb begin
    step_nxt_o = step_q;
    if (reversal) begin
      step_nxt_o = (step_half == '0) ? STEP_MIN : step_half;
    end
  end

  always_comb begin
    rev_cnt_nxt = rev_cnt_q;
    if (reversal && step_q == STEP_MIN && rev_cnt_q != CNT_TOP) begin
      rev_cnt_nxt = rev_cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= STEP_INIT;
      prev_dir_q <= 1'b0;
      primed_q   <= 1'b0;
      rev_cnt_q  <= '0;
      lock_q     <= 1'b0;
    end else if (en_i) begin
      step_q     <= step_nxt_o;
      prev_dir_q <= dir_i;
      primed_q   <= 1'b1;
      rev_cnt_q  <= rev_cnt_nxt;
      lock_q     <= (step_nxt_o == STEP_MIN) && (rev_cnt_nxt == CNT_TOP);
    end
  end

  assign lock_o = lock_q;

  AST_STEP_POW2: assert property (@(posedge clk) disable iff (rst)
    $countones(step_q) == 1); // R4
  AST_STEP_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> step_q <= $past(step_q)); // R4
  AST_LOCK_AT_MIN: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> step_q == STEP_MIN); // R8
  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q); // R8

endmodule

// File: rtl/dds_tw_reg.sv
module dds_tw_reg #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] tw_o
);
  import dds_trk_pkg::*;

  localparam logic [ACC_W:0]   TW_CEIL_W = (ACC_W+1)'(1) << (ACC_W - 2);
  localparam logic [ACC_W-1:0] TW_CEIL   = ACC_W'(1) << (ACC_W - 2);
  localparam logic [ACC_W-1:0] TW_FLOOR  = ACC_W'(1);

  logic [ACC_W-1:0] tw_q;
  logic [ACC_W-1:0] tw_nxt;
  logic [ACC_W:0]   up_sum;

  assign up_sum = {1'b0, tw_q} + {1'b0, step_i};

  always_comb begin
    if (dir_e'(dir_i) == DIR_UP) begin
      tw_nxt = (up_sum > TW_CEIL_W) ? TW_CEIL : up_sum[ACC_W-1:0];
    end else begin
      tw_nxt = (tw_q <= step_i) ? TW_FLOOR : (tw_q - step_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_q <= '0;
    end else if (en_i) begin
      tw_q <= tw_nxt;
    end
  end

  assign tw_o = tw_q;

  AST_TW_CEIL: assert property (@(posedge clk) disable iff (rst)
    tw_q <= TW_CEIL); // R5
  AST_TW_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (tw_q != '0) |=> (tw_q != '0)); // R6
  AST_TW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(tw_q)); // R7
  AST_TW_UP_DIR: assert property (@(posedge clk) disable iff (rst)
    (en_i && dir_i) |=> tw_q >= $past(tw_q)); // R3

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tw_i,
  output logic             msb_o
);

  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + tw_i;
    end
  end

  assign msb_o = phase_q[ACC_W-1];

  AST_SQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(tw_i) == '0) |-> $stable(msb_o)); // R9

endmodule

// File: rtl/dds_freq_tracker.sv
module dds_freq_tracker #(
  parameter int ACC_W     = 32,
  parameter int LOCK_REVS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             dir_i,
  output logic [ACC_W-1:0] tw_o,
  output logic             sq_o,
  output logic             lock_o
);

  logic [ACC_W-1:0] step_apply;

  initial begin
    assert (ACC_W >= 4) else $error("ACC_W too small");
  end

  dds_step_ctrl #(.ACC_W(ACC_W), .LOCK_REVS(LOCK_REVS)) u_step (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .dir_i      (dir_i),
    .step_nxt_o (step_apply),
    .lock_o     (lock_o)
  );

  dds_tw_reg #(.ACC_W(ACC_W)) u_tw (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .dir_i  (dir_i),
    .step_i (step_apply),
    .tw_o   (tw_o)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .tw_i  (tw_o),
    .msb_o (sq_o)
  );

endmodule

// File: tb/tb_dds_freq_tracker.sv
`timescale 1ns/1ps
module tb_dds_freq_tracker;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en_i = 1'b0;
  logic         dir_i = 1'b0;
  logic [W-1:0] tw_o;
  logic         sq_o;
  logic         lock_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dds_freq_tracker #(.ACC_W(W)) dut (
    .clk(clk), .rst(rst), .en_i(en_i), .dir_i(dir_i),
    .tw_o(tw_o), .sq_o(sq_o), .lock_o(lock_o)
  );

  // {en, dir, expected tw (12 bits), expected lock}; step starts at 512, ceiling 1024
  localparam logic [14:0] VEC [18] = '{
    {1'b1, 1'b1, 12'd512,  1'b0},  // R2 first update, no reversal
    {1'b1, 1'b1, 12'd1024, 1'b0},  // R3 up
    {1'b1, 1'b1, 12'd1024, 1'b0},  // R5 saturate
    {1'b1, 1'b0, 12'd768,  1'b0},  // R4 halve to 256
    {1'b1, 1'b0, 12'd512,  1'b0},  // R3 down, no halving
    {1'b1, 1'b1, 12'd640,  1'b0},  // R4 128
    {1'b0, 1'b0, 12'd640,  1'b0},  // R7 hold
    {1'b1, 1'b1, 12'd768,  1'b0},  // R7 compares to last enabled bit
    {1'b1, 1'b0, 12'd704,  1'b0},  // R4 64
    {1'b1, 1'b1, 12'd736,  1'b0},  // 32
    {1'b1, 1'b0, 12'd720,  1'b0},  // 16
    {1'b1, 1'b1, 12'd728,  1'b0},  // 8
    {1'b1, 1'b0, 12'd724,  1'b0},  // 4
    {1'b1, 1'b1, 12'd726,  1'b0},  // 2
    {1'b1, 1'b0, 12'd725,  1'b0},  // R4 reaches 1
    {1'b1, 1'b1, 12'd726,  1'b0},  // R8 first reversal at 1
    {1'b1, 1'b0, 12'd725,  1'b1},  // R8 second reversal: lock
    {1'b1, 1'b0, 12'd724,  1'b1}   // R8 lock stays
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_in(input logic en, input logic dir);
    @(negedge clk);
    en_i  = en;
    dir_i = dir;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst  = 1'b1;
    en_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 tw", 32'(tw_o), 0);
    check("R1 lock", 32'(lock_o), 0);
    check("R1 sq", 32'(sq_o), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int highs;
    int rises;
    logic prev;
    do_reset();

    for (int i = 0; i < 18; i++) begin
      step_in(VEC[i][14], VEC[i][13]);
      check($sformatf("R3 tw vec %0d", i), 32'(tw_o), 32'(VEC[i][12:1]));
      check($sformatf("R8 lock vec %0d", i), 32'(lock_o), 32'(VEC[i][0]));
    end

    // R6 floor at 1
    do_reset();
    step_in(1'b1, 1'b1);
    check("R2 tw", 32'(tw_o), 512);
    step_in(1'b1, 1'b0);
    check("R6 tw", 32'(tw_o), 256);
    step_in(1'b1, 1'b0);
    check("R6 floor", 32'(tw_o), 1);
    step_in(1'b1, 1'b0);
    check("R6 floor hold", 32'(tw_o), 1);
    step_in(1'b1, 1'b1);
    check("R4 step 128 up", 32'(tw_o), 129);

    // R7 held enable keeps lock low and word fixed
    step_in(1'b0, 1'b0);
    step_in(1'b0, 1'b1);
    check("R7 hold tw", 32'(tw_o), 129);
    check("R7 hold lock", 32'(lock_o), 0);

    // R9 square wave with tuning word 512: period 8 clocks
    do_reset();
    step_in(1'b1, 1'b1);
    step_in(1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    highs = 0;
    rises = 0;
    prev = sq_o;
    for (int k = 0; k < 64; k++) begin
      @(posedge clk);
      #1;
      if (sq_o) highs++;
      if (sq_o && !prev) rises++;
      prev = sq_o;
    end
    check("R9 high count", 32'(highs), 32);
    check("R9 rises", 32'(rises), 8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule